// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits between a host data port and the controller's local packet RAM. Software first loads a current address and a transfer count. It then reads or writes the data port repeatedly, and each access moves one, two or four bytes. After every access the engine steps the address and lowers the count. When the address reaches the ring's upper page boundary exactly, the engine folds it back to the ring's lower page. When the count runs out, the engine raises a sticky completion flag.

The local RAM is modelled inside the block as a byte array with two windows. The first is a 32-byte station-address PROM, which is loaded at reset. The second is a packet window whose base and size are parameters. Bytes that fall outside both windows read as all ones, and writes to them are dropped. Read data is registered and appears one cycle after the access strobe.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, `cur_addr`, `cur_cnt`, `dma_done` and `acc_rvalid` are 0. The 32 PROM bytes hold source byte i/2 at byte i. The source bytes are: bytes 0..5 are the station address, most significant byte first; bytes 6..13 are 0x00; bytes 14 and 15 are 0x57.
- R2: The access length is 4 when `acc_dword` is 1. Otherwise it is 2 when `cfg_word` is 1, and 1 when both are 0. An access that is carried out advances `cur_addr` by that length.
- R3: If the advanced address equals `{ring_stop_pg, 8'h00}` exactly, `cur_addr` becomes `{ring_start_pg, 8'h00}` instead.
- R4: If `cur_cnt` is at most the access length, the count becomes 0 and `dma_done` is set. Otherwise the count drops by the length. `dma_done` stays set until `done_clr` is pulsed.
- R5: A write while `cur_cnt` is 0 is ignored completely: memory, address, count and flag all keep their values.
- R6: A read while `cur_cnt` is 0 is still carried out. It advances the address and sets `dma_done`.
- R7: Read data appears on `acc_rdata` with `acc_rvalid` high in the cycle after the strobe. The data is little-endian: the byte at the lowest address is in bits 7:0. Word and dword accesses use the current address with bit 0 cleared, and lanes above the access width read 0.
- R8: Each byte lane is checked on its own. A lane is valid when its address is below 32, or when it lies inside [PMEM_BASE, PMEM_BASE+PMEM_BYTES). Invalid lanes read 0xFF and drop writes. PROM bytes can be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_word | input | 1 | Word mode for non-dword accesses |
| ring_start_pg | input | PG_W | Ring lower page |
| ring_stop_pg | input | PG_W | Ring upper page (exclusive) |
| ld_addr | input | 1 | Load `addr_in` into the current address |
| addr_in | input | PG_W+8 | Address load value |
| ld_cnt | input | 1 | Load `cnt_in` into the count |
| cnt_in | input | CW | Count load value |
| acc_req | input | 1 | Data port access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_dword | input | 1 | Four-byte access |
| acc_wdata | input | 32 | Write data, little-endian |
| acc_rdata | output | 32 | Registered read data |
| acc_rvalid | output | 1 | Read data valid |
| cur_addr | output | PG_W+8 | Current transfer address |
| cur_cnt | output | CW | Remaining byte count |
| done_clr | input | 1 | Clears the completion flag |
| dma_done | output | 1 | Sticky transfer-complete flag |

## Verification
The whole packet window is filled with dword writes, and a final wrap shows that an exact hit on the stop page returns the address to the start page. Each of the three access widths is swept over counts 1 to 9. The starts are odd and even and sit just below the stop boundary, and each write pass is read back, which separates alignment errors from wrap errors and off-by-one completion. Accesses at count 0 separate the read path, which still advances the address, from the write path, which is frozen. Reads that straddle the PROM edge and the gap below the packet window show whether validity is decided per lane.

// File: rtl/rdma_port_engine.sv
module rdma_port_engine #(
  parameter int          PG_W       = 8,
  parameter int          CW         = 16,
  parameter int          PMEM_BASE  = 16'h0400,
  parameter int          PMEM_BYTES = 1024,
  parameter logic [47:0] STATION    = 48'h02_00_5E_10_20_30,
  parameter logic [7:0]  PROM_TAG   = 8'h57
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_word,
  input  logic [PG_W-1:0]   ring_start_pg,
  input  logic [PG_W-1:0]   ring_stop_pg,
  input  logic              ld_addr,
  input  logic [PG_W+7:0]   addr_in,
  input  logic              ld_cnt,
  input  logic [CW-1:0]     cnt_in,
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic              acc_dword,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_rvalid,
  output logic [PG_W+7:0]   cur_addr,
  output logic [CW-1:0]     cur_cnt,
  input  logic              done_clr,
  output logic              dma_done
);
  localparam int AW         = PG_W + 8;
  localparam int PROM_BYTES = 32;
  localparam int MEM_N      = PROM_BYTES + PMEM_BYTES;
  localparam int IW         = $clog2(MEM_N);

  function automatic logic [7:0] prom_byte(input int i);
    int s;
    s = i / 2;
    if (s < 6)       return STATION[47 - 8*s -: 8];
    else if (s >= 14) return PROM_TAG;
    else             return 8'h00;
  endfunction

  logic [7:0]    mem [MEM_N];
  logic [2:0]    len;
  logic [AW-1:0] base, step, next_addr, stop_a, start_a;
  logic          fire, cnt_le;
  logic [AW-1:0] la   [4];
  logic [IW-1:0] lidx [4];
  logic [7:0]    lrd  [4];
  logic [3:0]    lok;

  assign len       = acc_dword ? 3'd4 : (cfg_word ? 3'd2 : 3'd1);
  assign base      = (len != 3'd1) ? {cur_addr[AW-1:1], 1'b0} : cur_addr;
  assign fire      = acc_req && !(acc_wr && cur_cnt == '0);
  assign stop_a    = {ring_stop_pg, 8'h00};
  assign start_a   = {ring_start_pg, 8'h00};
  assign step      = cur_addr + AW'(len);
  assign next_addr = (step == stop_a) ? start_a : step;
  assign cnt_le    = cur_cnt <= CW'(len);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [31:0] a32;
    logic        in_prom, in_pm;
    assign la[g]   = base + AW'(g);
    assign a32     = 32'(la[g]);
    assign in_prom = a32 < 32'(PROM_BYTES);
    assign in_pm   = a32 >= 32'(PMEM_BASE) && a32 < 32'(PMEM_BASE + PMEM_BYTES);
    assign lok[g]  = (3'(g) < len) && (in_prom || in_pm);
    assign lidx[g] = in_prom ? IW'(a32) : IW'(a32 - 32'(PMEM_BASE) + 32'(PROM_BYTES));
    assign lrd[g]  = lok[g] ? mem[lidx[g]] : ((3'(g) < len) ? 8'hFF : 8'h00);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PROM_BYTES; i++) mem[i] <= prom_byte(i);
    end else if (fire && acc_wr) begin
      for (int k = 0; k < 4; k++)
        if (lok[k]) mem[lidx[k]] <= acc_wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      cur_cnt    <= '0;
      dma_done   <= 1'b0;
      acc_rvalid <= 1'b0;
      acc_rdata  <= '0;
    end else begin
      acc_rvalid <= acc_req && !acc_wr;
      if (acc_req && !acc_wr) acc_rdata <= {lrd[3], lrd[2], lrd[1], lrd[0]};
      if (ld_addr)   cur_addr <= addr_in;
      else if (fire) cur_addr <= next_addr;
      if (ld_cnt)    cur_cnt <= cnt_in;
      else if (fire) cur_cnt <= cnt_le ? '0 : cur_cnt - CW'(len);
      if (fire && cnt_le) dma_done <= 1'b1;
      else if (done_clr)  dma_done <= 1'b0;
    end
  end

  a_r3_never_parks_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ld_addr && start_a != stop_a |=> cur_addr != {ring_stop_pg, 8'h00});

  a_r4_done_when_exhausted: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cnt_le && !ld_cnt |=> dma_done && cur_cnt == '0);

  a_r4_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cnt_le && !ld_cnt |=> cur_cnt < $past(cur_cnt) && cur_cnt != '0);

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done && !done_clr |=> dma_done);

  a_r5_write_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_wr && cur_cnt == '0 && !ld_addr && !ld_cnt |=> $stable(cur_addr) && cur_cnt == '0);

  a_r7_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_wr |=> acc_rvalid);

  a_r7_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_req && !acc_wr) |=> !acc_rvalid);
endmodule

// File: tb/test_rdma_port_engine.sv
module test_rdma_port_engine;
  localparam int CLK_P = 10;
  localparam logic [47:0] STA = 48'h02_00_5E_10_20_30;
  localparam int PB = 16'h0400;
  localparam int PN = 1024;
  localparam logic [7:0] SPG = 8'h04;
  localparam logic [7:0] EPG = 8'h08;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, cfg_word, ld_addr, ld_cnt, acc_req, acc_wr, acc_dword, done_clr;
  logic [7:0] ring_start_pg, ring_stop_pg;
  logic [15:0] addr_in, cnt_in, cur_addr, cur_cnt;
  logic [31:0] acc_wdata, acc_rdata;
  logic acc_rvalid, dma_done;

  rdma_port_engine #(.PMEM_BASE(PB), .PMEM_BYTES(PN), .STATION(STA)) i_rdma_port_engine (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg),
    .ld_addr(ld_addr), .addr_in(addr_in), .ld_cnt(ld_cnt), .cnt_in(cnt_in),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_dword(acc_dword), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
    .done_clr(done_clr), .dma_done(dma_done));

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] sprom [32];
  logic [7:0] spm [PN];
  logic [15:0] m_addr, m_cnt;
  logic m_done;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] srd(input int a);
    if (a < 32) return sprom[a];
    if (a >= PB && a < PB + PN) return spm[a - PB];
    return 8'hFF;
  endfunction

  task automatic swr(input int a, input logic [7:0] v);
    if (a < 32) sprom[a] = v;
    else if (a >= PB && a < PB + PN) spm[a - PB] = v;
  endtask

  task automatic acc(input bit wr, input bit dw, input logic [31:0] d, input string tag);
    int len;
    logic [15:0] base;
    logic [31:0] er;
    bit skip;
    len  = dw ? 4 : (cfg_word ? 2 : 1);
    base = (len > 1) ? (m_addr & 16'hFFFE) : m_addr;
    skip = wr && m_cnt == 0;
    er   = '0;
    for (int k = 0; k < len; k++) begin
      int la;
      la = int'(16'(base + 16'(k)));
      if (wr) begin
        if (!skip) swr(la, d[8*k +: 8]);
      end else er[8*k +: 8] = srd(la);
    end
    if (!skip) begin
      m_addr = 16'(m_addr + 16'(len));
      if (m_addr == {EPG, 8'h00}) m_addr = {SPG, 8'h00};
      if (int'(m_cnt) <= len) begin m_cnt = 0; m_done = 1'b1; end
      else m_cnt = 16'(m_cnt - 16'(len));
    end
    @(negedge clk);
    acc_req = 1'b1; acc_wr = wr; acc_dword = dw; acc_wdata = d;
    @(negedge clk);
    acc_req = 1'b0;
    chk({tag, " R2/R3 addr"}, 32'(cur_addr), 32'(m_addr));
    chk({tag, " R4 count"}, 32'(cur_cnt), 32'(m_cnt));
    chk({tag, " R4 done"}, 32'(dma_done), 32'(m_done));
    if (!wr) begin
      chk({tag, " R7 rvalid"}, 32'(acc_rvalid), 32'd1);
      chk({tag, " R7/R8 rdata"}, acc_rdata, er);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    ld_addr = 1'b1; addr_in = a; ld_cnt = 1'b1; cnt_in = c;
    @(negedge clk);
    ld_addr = 1'b0; ld_cnt = 1'b0;
    m_addr = a; m_cnt = c;
  endtask

  task automatic clear_done();
    @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    m_done = 1'b0;
    chk("R4 done cleared", 32'(dma_done), 32'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_word = 1'b0; ld_addr = 1'b0; ld_cnt = 1'b0; acc_req = 1'b0;
    acc_wr = 1'b0; acc_dword = 1'b0; done_clr = 1'b0; addr_in = '0; cnt_in = '0;
    acc_wdata = '0; ring_start_pg = SPG; ring_stop_pg = EPG;
    m_addr = '0; m_cnt = '0; m_done = 1'b0;
    for (int i = 0; i < 32; i++) begin
      int s;
      s = i / 2;
      if (s < 6) sprom[i] = 8'((STA >> (8 * (5 - s))) & 48'hFF);
      else if (s >= 14) sprom[i] = 8'h57;
      else sprom[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset addr", 32'(cur_addr), 0);
    chk("R1 reset count", 32'(cur_cnt), 0);
    chk("R1 reset done", 32'(dma_done), 0);
    chk("R1 reset rvalid", 32'(acc_rvalid), 0);

    for (int i = 0; i < 32; i++) acc(1'b0, 1'b0, '0, "R1 R6 prom byte read");
    clear_done();

    load(16'h0400, 16'(PN));
    for (int k = 0; k < PN / 4; k++)
      acc(1'b1, 1'b1, 32'(k) * 32'h0101_0101 ^ 32'hA5C3_0F96, "R3 fill dword");
    chk("R3 wrapped to start page", 32'(cur_addr), 32'h0400);

    acc(1'b1, 1'b1, 32'hDEAD_BEEF, "R5 write at zero count");
    load(16'h0400, 16'd0);
    acc(1'b0, 1'b1, '0, "R5 readback unchanged");
    acc(1'b0, 1'b0, '0, "R6 zero-count read");

    for (int mode = 0; mode < 3; mode++) begin
      for (int n = 1; n <= 9; n++) begin
        int nacc;
        logic [15:0] st;
        cfg_word = (mode == 1);
        st = 16'(16'h07F8 + 16'(n));
        nacc = (n + (mode == 0 ? 1 : (mode == 1 ? 2 : 4)) - 1) / (mode == 0 ? 1 : (mode == 1 ? 2 : 4)) + 1;
        clear_done();
        load(st, 16'(n));
        for (int j = 0; j < nacc; j++)
          acc(1'b1, mode == 2, 32'(n * 16 + j) * 32'h0001_0203 + 32'h1100_0000, "R2 R4 sweep write");
        clear_done();
        load(st, 16'(n));
        for (int j = 0; j < nacc; j++) acc(1'b0, mode == 2, '0, "R2 R7 sweep read");
      end
    end

    cfg_word = 1'b0;
    load(16'h001E, 16'd8);
    acc(1'b0, 1'b1, '0, "R8 dword straddles prom edge");
    load(16'h00FF, 16'd8);
    cfg_word = 1'b1;
    acc(1'b0, 1'b0, '0, "R8 word outside window");
    cfg_word = 1'b0;
    load(16'h03FF, 16'd8);
    acc(1'b0, 1'b0, '0, "R8 byte below window");
    acc(1'b0, 1'b0, '0, "R8 byte at window base");
    load(16'h001C, 16'd4);
    acc(1'b1, 1'b1, 32'hC0DE_F00D, "R8 prom write");
    load(16'h001C, 16'd4);
    acc(1'b0, 1'b1, '0, "R8 prom readback");
    load(16'h0100, 16'd4);
    acc(1'b1, 1'b0, 32'h0000_0042, "R8 write outside dropped");
    load(16'h0100, 16'd4);
    acc(1'b0, 1'b0, '0, "R8 outside still reads ones");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule